// File: doc/BRIEF.md
# GF(2) Subspace Intersection Calculator

This block takes two sets of bit-vectors, each set a list of up to `MAX_VECS` vectors of `VEC_W` bits, and reports how the spans of the two sets overlap. It applies Gaussian elimination over GF(2), where adding is XOR and multiplying is AND. From that it returns the rank of each set, the rank of the two sets joined, and the dimension of their intersection. The dimension comes from rank(A) + rank(B) − rank(A ∪ B).

The intended use is to predict shared-memory bank conflicts without walking the addresses. Load one set with the segment directions of a memory layout and the other with the thread directions of an access. The intersection dimension d then gives the number of serialized wavefronts, 2^d. The access is conflict-free exactly when d is zero.

For the default 9-bit space, a 16-row by 32-column tile gives these results:

| Layout | Intersection dimension | Wavefronts |
|---|---|---|
| No swizzle | 4 | 16 |
| Row index XORed into the column | 1 | 2 |
| Doubled row index XORed into the column | 0 | 1 |

Vectors are loaded one at a time through a write port. A start pulse launches a run, and a one-cycle done pulse marks the moment the results are ready.

Top module: `gf2_isect_calc`

## Requirements
- R1: After reset, `busy` and `done` are 0, all three ranks and `isect_dim` are 0, `wavefronts` is 1 and `conflict_free` is 1.
- R2: `rank_a` and `rank_b` equal the GF(2) rank of the first `count_a` and `count_b` stored vectors of each set. Zero vectors, repeated vectors and vectors that are XOR combinations of earlier ones do not raise a rank. A count of 0 gives rank 0.
- R3: `rank_u` equals the GF(2) rank of the union of both active vector lists.
- R4: `isect_dim` equals `rank_a + rank_b - rank_u`.
- R5: `wavefronts` equals 2 raised to `isect_dim`. `conflict_free` is 1 exactly when `isect_dim` is 0.
- R6: `done` is high for exactly one cycle. It rises no more than `2*MAX_VECS+2` clock cycles after the cycle in which `start` was accepted. The result outputs change only together with `done` and then hold until the next run completes.
- R7: A `start` pulse that arrives while `busy` is 1 is ignored. No extra run and no extra `done` pulse follow from it.
- R8: A write with `wr_en`=1 stores `wr_data` in slot `wr_idx` of set A when `wr_set`=0, or of set B when `wr_set`=1. Writes to slots at or above `MAX_VECS` are dropped. Writes made while `busy` is 1 are dropped.
- R9: `count_a` and `count_b` are sampled with `start`. Stored vectors in slots at or above the count are not used. A count above `MAX_VECS` acts as `MAX_VECS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Vector write strobe |
| wr_set | input | 1 | Target set: 0 = A, 1 = B |
| wr_idx | input | IDX_W | Slot index within the set |
| wr_data | input | VEC_W | Vector to store |
| start | input | 1 | Launch a run (accepted when idle) |
| count_a | input | CNT_W | Number of active vectors in set A |
| count_b | input | CNT_W | Number of active vectors in set B |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse: results updated |
| rank_a | output | RANK_W | Rank of set A |
| rank_b | output | RANK_W | Rank of set B |
| rank_u | output | RANK_W | Rank of the union of both sets |
| isect_dim | output | RANK_W | Dimension of the intersection of the spans |
| wavefronts | output | VEC_W+1 | 2 to the power isect_dim |
| conflict_free | output | 1 | High when the intersection is trivial |

## Verification
The bench checks the three swizzles of a 16×32 tile and expects dimensions 4, 1 and 0. A design that mixed up the pivot order or the union bookkeeping would report the wrong number of wavefronts there.

Further cases cover the following:
- Sets holding zero, repeated and dependent vectors. A design that counted every nonzero input would give inflated ranks and a negative-looking dimension.
- A zero count, a count above capacity, and stale vectors stored beyond the count. These catch an off-by-one in slot selection.
- A start pulse and a vector write while the block is busy. A design that restarted would pulse done twice. A design that accepted the write would change the result of a later rerun made without reloading.
- Full-rank sets, which reach the widest `wavefronts` value, 512.

// File: rtl/gf2_isect_pkg.sv
// Package: shared types and table indices for the GF(2) intersection block.
// Assumes nothing beyond IEEE 1800-2017.
package gf2_isect_pkg;

    // Sequencer states: idle, elimination steps, result capture.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } run_state_t;

    // Pivot table roles: set A alone, set B alone, union of both.
    localparam int TBL_A   = 0;
    localparam int TBL_B   = 1;
    localparam int TBL_U   = 2;
    localparam int NUM_TBL = 3;

endpackage

// File: rtl/gf2_vec_store.sv
// Module: gf2_vec_store
// Holds two banks of MAX_VECS vectors of VEC_W bits, one bank per set.
// The write port is gated by the caller. Out-of-range slots are dropped.
// The read is combinational, selected by set and slot.
module gf2_vec_store #(
    parameter int VEC_W    = 9,
    parameter int MAX_VECS = 9,
    localparam int IDX_W   = (MAX_VECS > 1) ? $clog2(MAX_VECS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_set,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VEC_W-1:0] wr_data,
    input  logic             rd_set,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [VEC_W-1:0] rd_vec
);

    logic [VEC_W-1:0] bank_a [MAX_VECS];
    logic [VEC_W-1:0] bank_b [MAX_VECS];

    // Store an incoming vector in the addressed bank and slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_VECS; i++) begin
                bank_a[i] <= '0;
                bank_b[i] <= '0;
            end
        end else if (wr_en && (int'(wr_idx) < MAX_VECS)) begin
            if (wr_set) bank_b[wr_idx] <= wr_data;
            else        bank_a[wr_idx] <= wr_data;
        end
    end

    // Select the vector that the current elimination step consumes.
    always_comb begin
        rd_vec = '0;
        if (int'(rd_idx) < MAX_VECS)
            rd_vec = rd_set ? bank_b[rd_idx] : bank_a[rd_idx];
    end

endmodule

// File: rtl/gf2_pivot_table.sv
// Module: gf2_pivot_table
// Incremental GF(2) row reduction. Slot b holds a reduced vector whose
// highest set bit is b. On each enabled cycle the input is reduced against
// all slots, from the top bit down. A nonzero remainder is stored at its
// leading bit. The rank is the number of occupied slots.
// Assumes the caller clears the table before each run.
module gf2_pivot_table #(
    parameter int VEC_W   = 9,
    localparam int RANK_W = $clog2(VEC_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              ins_en,
    input  logic [VEC_W-1:0]  vec_in,
    output logic [RANK_W-1:0] rank
);

    logic [VEC_W-1:0] piv     [VEC_W];
    logic [VEC_W-1:0] piv_vld;
    logic [VEC_W-1:0] residue;
    logic [VEC_W-1:0] lead_oh;

    // Reduce the input against existing pivots, highest bit first.
    always_comb begin
        residue = vec_in;
        for (int b = VEC_W - 1; b >= 0; b--) begin
            if (residue[b] && piv_vld[b])
                residue = residue ^ piv[b];
        end
    end

    // One-hot marker of the highest set bit of the residue.
    always_comb begin
        lead_oh = '0;
        for (int b = 0; b < VEC_W; b++) begin
            if (residue[b]) lead_oh = '0;
            if (residue[b]) lead_oh[b] = 1'b1;
        end
    end

    // Insert a nonzero residue at its leading bit, or clear the table.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            piv_vld <= '0;
            for (int b = 0; b < VEC_W; b++) piv[b] <= '0;
        end else if (ins_en && (residue != '0)) begin
            for (int b = 0; b < VEC_W; b++) begin
                if (lead_oh[b]) begin
                    piv[b]     <= residue;
                    piv_vld[b] <= 1'b1;
                end
            end
        end
    end

    // Rank is the population count of occupied pivot slots.
    always_comb begin
        rank = '0;
        for (int b = 0; b < VEC_W; b++)
            rank = rank + RANK_W'(piv_vld[b]);
    end

endmodule

// File: rtl/gf2_seq_ctrl.sv
// Module: gf2_seq_ctrl
// Run sequencer. A start seen while idle latches the counts, clears the
// tables and walks 2*MAX_VECS steps. The first half feeds set A and the
// second half feeds set B, one slot per step. Every active vector also
// goes to the union table. A one-cycle capture strobe follows the steps.
// Assumes start is a level sampled only in the idle state.
module gf2_seq_ctrl
    import gf2_isect_pkg::*;
#(
    parameter int MAX_VECS = 9,
    localparam int IDX_W   = (MAX_VECS > 1) ? $clog2(MAX_VECS) : 1,
    localparam int CNT_W   = $clog2(MAX_VECS + 1),
    localparam int STEPS   = 2 * MAX_VECS,
    localparam int STEP_W  = $clog2(STEPS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [CNT_W-1:0]   count_a,
    input  logic [CNT_W-1:0]   count_b,
    output logic               busy,
    output logic               tbl_clear,
    output logic [NUM_TBL-1:0] tbl_en,
    output logic               rd_set,
    output logic [IDX_W-1:0]   rd_idx,
    output logic               capture
);

    run_state_t        state_q;
    logic [STEP_W-1:0] step_q;
    logic [CNT_W-1:0]  cnt_a_q;
    logic [CNT_W-1:0]  cnt_b_q;
    logic              in_a;
    logic              slot_live;
    int                loc;

    // Decode the current step into set, slot and slot-active flag.
    always_comb begin
        in_a      = int'(step_q) < MAX_VECS;
        loc       = in_a ? int'(step_q) : int'(step_q) - MAX_VECS;
        slot_live = in_a ? (loc < int'(cnt_a_q)) : (loc < int'(cnt_b_q));
        rd_set    = !in_a;
        rd_idx    = IDX_W'(loc);
    end

    // Route the active slot to its own table and to the union table.
    always_comb begin
        tbl_en        = '0;
        tbl_en[TBL_A] = (state_q == ST_RUN) && slot_live && in_a;
        tbl_en[TBL_B] = (state_q == ST_RUN) && slot_live && !in_a;
        tbl_en[TBL_U] = (state_q == ST_RUN) && slot_live;
    end

    assign busy      = (state_q != ST_IDLE);
    assign tbl_clear = (state_q == ST_IDLE) && start;
    assign capture   = (state_q == ST_FIN);

    // Advance the run state and step counter, and latch counts at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            cnt_a_q <= '0;
            cnt_b_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    step_q <= '0;
                    if (start) begin
                        cnt_a_q <= count_a;
                        cnt_b_q <= count_b;
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (int'(step_q) == STEPS - 1) state_q <= ST_FIN;
                    else                           step_q  <= step_q + 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/gf2_isect_calc.sv
// Module: gf2_isect_calc (top)
// Loads two vector sets, then ranks set A, set B and their union with three
// pivot tables fed in one pass of 2*MAX_VECS steps. It reports the
// intersection dimension, 2^dimension and a conflict-free flag.
// Assumes synchronous active-low reset. Writes are dropped while busy.
module gf2_isect_calc
    import gf2_isect_pkg::*;
#(
    parameter int VEC_W    = 9,
    parameter int MAX_VECS = 9,
    localparam int IDX_W   = (MAX_VECS > 1) ? $clog2(MAX_VECS) : 1,
    localparam int CNT_W   = $clog2(MAX_VECS + 1),
    localparam int RANK_W  = $clog2(VEC_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_set,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VEC_W-1:0]  wr_data,
    input  logic              start,
    input  logic [CNT_W-1:0]  count_a,
    input  logic [CNT_W-1:0]  count_b,
    output logic              busy,
    output logic              done,
    output logic [RANK_W-1:0] rank_a,
    output logic [RANK_W-1:0] rank_b,
    output logic [RANK_W-1:0] rank_u,
    output logic [RANK_W-1:0] isect_dim,
    output logic [VEC_W:0]    wavefronts,
    output logic              conflict_free
);

    logic               tbl_clear;
    logic [NUM_TBL-1:0] tbl_en;
    logic               rd_set;
    logic [IDX_W-1:0]   rd_idx;
    logic [VEC_W-1:0]   rd_vec;
    logic               capture;
    logic [RANK_W-1:0]  tbl_rank [NUM_TBL];
    logic [RANK_W-1:0]  dim_c;

    gf2_seq_ctrl #(.MAX_VECS(MAX_VECS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .count_a   (count_a),
        .count_b   (count_b),
        .busy      (busy),
        .tbl_clear (tbl_clear),
        .tbl_en    (tbl_en),
        .rd_set    (rd_set),
        .rd_idx    (rd_idx),
        .capture   (capture)
    );

    gf2_vec_store #(.VEC_W(VEC_W), .MAX_VECS(MAX_VECS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en && !busy),
        .wr_set  (wr_set),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_set  (rd_set),
        .rd_idx  (rd_idx),
        .rd_vec  (rd_vec)
    );

    // One pivot table per role: A alone, B alone, and the union.
    for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
        gf2_pivot_table #(.VEC_W(VEC_W)) u_tbl (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (tbl_clear),
            .ins_en (tbl_en[t]),
            .vec_in (rd_vec),
            .rank   (tbl_rank[t])
        );
    end

    // Intersection dimension from the three ranks.
    assign dim_c = tbl_rank[TBL_A] + tbl_rank[TBL_B] - tbl_rank[TBL_U];

    // Capture the results and pulse done once per run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done          <= 1'b0;
            rank_a        <= '0;
            rank_b        <= '0;
            rank_u        <= '0;
            isect_dim     <= '0;
            wavefronts    <= (VEC_W+1)'(1);
            conflict_free <= 1'b1;
        end else begin
            done <= capture;
            if (capture) begin
                rank_a        <= tbl_rank[TBL_A];
                rank_b        <= tbl_rank[TBL_B];
                rank_u        <= tbl_rank[TBL_U];
                isect_dim     <= dim_c;
                wavefronts    <= (VEC_W+1)'(1) << dim_c;
                conflict_free <= (dim_c == '0);
            end
        end
    end

endmodule

// File: rtl/gf2_isect_calc_chk.sv
// Module: gf2_isect_calc_chk
// Property checker for gf2_isect_calc, attached with bind below.
// Assumes synchronous active-low reset on rst_n.
module gf2_isect_calc_chk #(
    parameter int VEC_W    = 9,
    localparam int RANK_W  = $clog2(VEC_W + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [RANK_W-1:0] rank_a,
    input logic [RANK_W-1:0] rank_b,
    input logic [RANK_W-1:0] rank_u,
    input logic [RANK_W-1:0] isect_dim,
    input logic [VEC_W:0]    wavefronts,
    input logic              conflict_free
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R6

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (done || $stable(isect_dim)));  // R6

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));  // R7

    AST_UNION_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rank_u >= rank_a && rank_u >= rank_b &&
                  {1'b0, rank_u} <= ({1'b0, rank_a} + {1'b0, rank_b})));  // R3

    AST_DIM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (isect_dim <= rank_a && isect_dim <= rank_b));  // R4

    AST_WAVE_POW2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones(wavefronts) == 1));  // R5

    AST_FREE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (conflict_free == (wavefronts == (VEC_W+1)'(1))));  // R5

endmodule

bind gf2_isect_calc gf2_isect_calc_chk #(.VEC_W(VEC_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .busy          (busy),
    .done          (done),
    .rank_a        (rank_a),
    .rank_b        (rank_b),
    .rank_u        (rank_u),
    .isect_dim     (isect_dim),
    .wavefronts    (wavefronts),
    .conflict_free (conflict_free)
);

// File: tb/gf2_isect_calc_test.sv
// Scoreboard bench: the driver loads vectors, computes expected ranks by
// enumerating spans, queues them and starts a run. The monitor compares
// on each done pulse.
module gf2_isect_calc_test;

    localparam int CLK_PERIOD = 10;
    localparam int VW   = 9;
    localparam int MV   = 9;
    localparam int IW   = $clog2(MV);
    localparam int CW   = $clog2(MV + 1);
    localparam int RW   = $clog2(VW + 1);
    localparam int SPAN = 1 << VW;

    typedef struct {
        string tag;
        int    ra;
        int    rb;
        int    ru;
        int    dim;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_set = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [VW-1:0] wr_data = '0;
    logic          start = 1'b0;
    logic [CW-1:0] count_a = '0;
    logic [CW-1:0] count_b = '0;
    logic          busy, done, conflict_free;
    logic [RW-1:0] rank_a, rank_b, rank_u, isect_dim;
    logic [VW:0]   wavefronts;

    int   n_cmp = 0;
    int   n_bad = 0;
    exp_t sb_q[$];
    logic [VW-1:0] mdl_a [MV];
    logic [VW-1:0] mdl_b [MV];

    gf2_isect_calc #(.VEC_W(VW), .MAX_VECS(MV)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_set(wr_set),
        .wr_idx(wr_idx), .wr_data(wr_data), .start(start),
        .count_a(count_a), .count_b(count_b), .busy(busy), .done(done),
        .rank_a(rank_a), .rank_b(rank_b), .rank_u(rank_u),
        .isect_dim(isect_dim), .wavefronts(wavefronts),
        .conflict_free(conflict_free)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Rank by span enumeration: size of the reachable set is 2^rank.
    function automatic int span_rank(input logic [VW-1:0] vs [2*MV], input int n);
        bit reach [SPAN];
        bit nxt   [SPAN];
        int size = 0;
        int r = 0;
        for (int x = 0; x < SPAN; x++) reach[x] = (x == 0);
        for (int i = 0; i < n; i++) begin
            nxt = reach;
            for (int x = 0; x < SPAN; x++)
                if (reach[x]) nxt[x ^ int'(vs[i])] = 1'b1;
            reach = nxt;
        end
        for (int x = 0; x < SPAN; x++) size += int'(reach[x]);
        while ((1 << r) < size) r++;
        return r;
    endfunction

    // Write one vector through the port; the model follows when idle. R8
    task automatic put(input bit set, input int idx, input logic [VW-1:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_set = set; wr_idx = IW'(idx); wr_data = v;
        if (idx < MV && !busy) begin
            if (set) mdl_b[idx] = v;
            else     mdl_a[idx] = v;
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Queue the expected result, launch a run and time it.
    task automatic run_case(input string tag, input int ca, input int cb,
                            input bit poke_start, input bit poke_wr);
        logic [VW-1:0] la [2*MV];
        logic [VW-1:0] lb [2*MV];
        logic [VW-1:0] lu [2*MV];
        int ea, eb, nu = 0, lat = 0;
        exp_t e;
        ea = (ca > MV) ? MV : ca;
        eb = (cb > MV) ? MV : cb;
        for (int i = 0; i < 2*MV; i++) begin la[i] = '0; lb[i] = '0; lu[i] = '0; end
        for (int i = 0; i < ea; i++) begin la[i] = mdl_a[i]; lu[nu] = mdl_a[i]; nu++; end
        for (int i = 0; i < eb; i++) begin lb[i] = mdl_b[i]; lu[nu] = mdl_b[i]; nu++; end
        e.tag = tag;
        e.ra  = span_rank(la, ea);
        e.rb  = span_rank(lb, eb);
        e.ru  = span_rank(lu, nu);
        e.dim = e.ra + e.rb - e.ru;
        sb_q.push_back(e);
        @(negedge clk);
        start = 1'b1; count_a = CW'(ca); count_b = CW'(cb);
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done) begin
            if (lat == 3 && poke_start) start = 1'b1;   // R7 start while busy
            if (lat == 4) start = 1'b0;
            if (lat == 5 && poke_wr) begin             // R8 write while busy
                wr_en = 1'b1; wr_set = 1'b0; wr_idx = '0; wr_data = 9'h1FF;
            end
            if (lat == 6) wr_en = 1'b0;
            @(negedge clk);
            lat++;
            if (lat > 100) break;
        end
        start = 1'b0; wr_en = 1'b0;
        check(lat <= 2*MV + 2, {"R6 latency ", tag}, lat, 2*MV + 2);
        repeat (25) @(negedge clk);   // a second done here would hit an empty queue
        check(!busy, {"R7 idle after run ", tag}, int'(busy), 0);
    endtask

    // Monitor: compare each done against the head of the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R7 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    int d0;
                    e = sb_q.pop_front();
                    check(int'(rank_a) == e.ra, {"R2 rank_a ", e.tag}, int'(rank_a), e.ra);
                    check(int'(rank_b) == e.rb, {"R2 rank_b ", e.tag}, int'(rank_b), e.rb);
                    check(int'(rank_u) == e.ru, {"R3 rank_u ", e.tag}, int'(rank_u), e.ru);
                    check(int'(isect_dim) == e.dim, {"R4 dim ", e.tag}, int'(isect_dim), e.dim);
                    check(int'(wavefronts) == (1 << e.dim), {"R5 wavefronts ", e.tag},
                          int'(wavefronts), 1 << e.dim);
                    check(conflict_free == (e.dim == 0), {"R5 conflict_free ", e.tag},
                          int'(conflict_free), int'(e.dim == 0));
                    d0 = int'(isect_dim);
                    @(negedge clk);
                    check(!done, {"R6 done one cycle ", e.tag}, int'(done), 0);
                    check(int'(isect_dim) == d0, {"R6 result held ", e.tag}, int'(isect_dim), d0);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        summary();
        $finish;
    end

    // Driver: reset, then the test cases.
    initial begin
        for (int i = 0; i < MV; i++) begin mdl_a[i] = '0; mdl_b[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy && !done, "R1 busy/done", int'(busy) + int'(done), 0);
        check(rank_a == 0 && rank_b == 0 && rank_u == 0, "R1 ranks",
              int'(rank_a) + int'(rank_b) + int'(rank_u), 0);
        check(isect_dim == 0 && wavefronts == 1 && conflict_free, "R1 outputs",
              int'(wavefronts), 1);

        // Thread directions of the column read: row bits (5..8) and n0 (bit 0).
        put(1, 0, 9'h020); put(1, 1, 9'h040); put(1, 2, 9'h080);
        put(1, 3, 9'h100); put(1, 4, 9'h001);
        // R4 no swizzle: segment directions are the row bits, dim 4
        put(0, 0, 9'h020); put(0, 1, 9'h040); put(0, 2, 9'h080); put(0, 3, 9'h100);
        run_case("plain", 4, 5, 0, 0);
        // R5 row XORed into column: one shared direction, dim 1
        put(0, 0, 9'h021); put(0, 1, 9'h042); put(0, 2, 9'h084); put(0, 3, 9'h108);
        run_case("xor_m", 4, 5, 0, 0);
        // R5 doubled row XORed into column: conflict-free
        put(0, 0, 9'h022); put(0, 1, 9'h044); put(0, 2, 9'h088); put(0, 3, 9'h110);
        run_case("xor_2m", 4, 5, 0, 0);
        // R7 start pulsed while busy
        run_case("busy_start", 4, 5, 1, 0);
        // R2 zero, repeated and dependent vectors
        put(0, 0, 9'h000); put(0, 1, 9'h003); put(0, 2, 9'h003);
        put(0, 3, 9'h005); put(0, 4, 9'h006);
        put(1, 0, 9'h000); put(1, 1, 9'h001); put(1, 2, 9'h001);
        run_case("dup_zero", 5, 3, 0, 0);
        // R9 stale slots beyond the count are unused; R2 count 0
        put(0, 5, 9'h1F0); put(0, 6, 9'h0F0);
        run_case("count_limit", 3, 0, 0, 0);
        // R8 write while busy is dropped: rerun gives the same result
        run_case("busy_write", 5, 3, 0, 1);
        run_case("after_busy_write", 5, 3, 0, 0);
        // R8 out-of-range slot dropped; R9 count above capacity; full rank
        for (int i = 0; i < MV; i++) put(0, i, VW'(1) << i);
        for (int i = 0; i < MV; i++) put(1, i, VW'((i * 37 + 11) % 512));
        put(1, 12, 9'h155);
        run_case("full", MV, 15, 0, 0);
        run_case("overlap", 2, MV, 0, 0);

        repeat (5) @(negedge clk);
        check(sb_q.size() == 0, "R6 all results seen", sb_q.size(), 0);
        summary();
        $finish;
    end

endmodule